// File: doc/BRIEF.md
# Flash Programming Control Register

This block is the control and status register through which software launches and supervises program and erase operations on an on-chip non-volatile memory. A 32-bit register bus reaches two word addresses: the control register and a key register. Software loads a 4-bit operation code and sets the enable bit. It then writes two fixed key words to the key register, back to back. Its next write to the control register may set the start bit. For a non-zero code, the block pulses a start strobe to the flash operation engine. It holds the start bit at 1 until the engine reports completion. It records a failed completion and any low-voltage event seen during the operation as sticky error bits.

Launching operation code 0000 is a no-operation that finishes in one cycle. It issues no start strobe, and it is the only way to clear the three status bits. After the start bit falls, a guard counter marks the time during which software must not touch the register. The enable bit is the only field that a device reset returns to zero. All other fields are reset only at power-on.

The sequencer has five states. IDLE goes to LAUNCH on an accepted start with a non-zero code, and to CLEAR on an accepted start with code 0000. LAUNCH always goes to WAIT after one cycle. WAIT goes to GUARD when the engine reports done. CLEAR always goes to GUARD after one cycle. GUARD goes back to IDLE after the guard count, or to LAUNCH or CLEAR on a new accepted start. The key tracker has three states. KEY_IDLE goes to KEY_HALF on a write of the first key. KEY_HALF goes to KEY_ARMED on a write of the second key, and otherwise goes back to KEY_IDLE on any bus access. KEY_ARMED goes back to KEY_IDLE on any bus access, which also consumes the arm.

Top module: `nvc_ctrl`

## Requirements
- R1: A read of the control address returns the start bit in bit 15, the enable bit in bit 14, the error bit in bit 13, the low-voltage error bit in bit 12, the low-voltage status bit in bit 11 and the operation code in bits 3..0. All other bits read 0. Bits 13..11 ignore writes. The key address reads 0.
- R2: A control write with bit 15 set starts an operation only when the enable bit was already 1 before that write and the key sequence is armed. Otherwise no start happens, while the code and enable fields of that write are still stored.
- R3: The key sequence arms only on a write of KEY_A to the key address followed directly by a write of KEY_B to the key address. Any other bus access in between breaks it. The next bus access after arming disarms it, whether or not that access starts an operation.
- R4: A start with a non-zero code gives a one-cycle start strobe in the cycle after the write, with the engine code output equal to the stored code. The start bit reads 1 from that cycle until the cycle after the engine's done pulse.
- R5: While the start bit is 1, writes to the code and enable fields are ignored.
- R6: A done pulse with the fail input high sets the error bit. The bit stays set through later good operations.
- R7: The low-voltage error bit latches the low-voltage input only while an operation is in progress and the enable bit is 1.
- R8: The low-voltage status bit follows the low-voltage input one cycle later while the enable bit is 1, and reads 0 while it is 0. The detector enable output equals the enable bit.
- R9: A start with code 0000 gives no start strobe. It holds the start bit at 1 for exactly one cycle, then clears the error, low-voltage error and low-voltage status bits.
- R10: After the start bit falls, the guard output is high for exactly GUARD_CYCLES cycles.
- R11: A device reset clears only the enable bit. A power-on reset clears every field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| dev_rst_n | input | 1 | Device reset, active low, clears the enable bit and the key tracker |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from the address |
| eng_start | output | 1 | One-cycle start strobe to the engine |
| eng_op | output | 4 | Operation code to the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_fail | input | 1 | Engine failure flag, valid with done |
| lvd_en | output | 1 | Low-voltage detector enable |
| lvd_event | input | 1 | Live low-voltage event |
| guard_busy | output | 1 | High during the post-completion guard time |

## Verification
The assertions assume the engine raises done only while an operation is waiting for it. They also assume done never comes in the same cycle as its own start strobe, and that the fail flag has meaning only when it comes with done. The bench's engine model answers each start strobe with a single done pulse a fixed four cycles later. The bench drives the fail flag and the low-voltage input from the stimulus thread. It never pulses a reset while an operation is in flight.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
    typedef enum logic [2:0] {ST_IDLE, ST_LAUNCH, ST_WAIT, ST_CLEAR, ST_GUARD} op_state_t;
    typedef enum logic [1:0] {KEY_IDLE, KEY_HALF, KEY_ARMED} key_state_t;
    localparam int OPW         = 4;
    localparam int BIT_WR      = 15;
    localparam int BIT_WREN    = 14;
    localparam int BIT_ERR     = 13;
    localparam int BIT_LVDERR  = 12;
    localparam int BIT_LVDSTAT = 11;
endpackage

// File: rtl/nvc_unlock.sv
module nvc_unlock
    import nvc_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32,
    parameter logic [AW-1:0] KEY_ADDR = 1,
    parameter logic [DW-1:0] KEY_A = 32'h3C5A_A5C3,
    parameter logic [DW-1:0] KEY_B = 32'hC3A5_5A3C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          armed
);
    key_state_t state, state_nx;
    logic key_wr, any_acc, first_ok;

    assign key_wr   = bus_wr && (bus_addr == KEY_ADDR);
    assign any_acc  = bus_wr || bus_rd;
    assign first_ok = key_wr && (bus_wdata == KEY_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= KEY_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            KEY_IDLE:  if (first_ok) state_nx = KEY_HALF;
            KEY_HALF:  begin
                if (key_wr && bus_wdata == KEY_B) state_nx = KEY_ARMED;
                else if (any_acc) state_nx = first_ok ? KEY_HALF : KEY_IDLE;
            end
            KEY_ARMED: if (any_acc) state_nx = first_ok ? KEY_HALF : KEY_IDLE;
            default:   state_nx = KEY_IDLE;
        endcase
    end

    always_comb armed = (state == KEY_ARMED);
endmodule

// File: rtl/nvc_fsm.sv
module nvc_fsm
    import nvc_pkg::*;
#(
    parameter int GUARD_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic op_nop,
    input  logic eng_done,
    output logic eng_start,
    output logic wr_bit,
    output logic guard_busy,
    output logic clr_stat,
    output logic done_evt,
    output logic in_op
);
    localparam int GW = $clog2(GUARD_CYCLES + 1);
    localparam logic [GW-1:0] GLAST = GW'(GUARD_CYCLES - 1);

    op_state_t state, state_nx;
    logic [GW-1:0] gcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            gcnt  <= '0;
        end else begin
            state <= state_nx;
            gcnt  <= (state == ST_GUARD && state_nx == ST_GUARD) ? gcnt + 1'b1 : '0;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (launch) state_nx = op_nop ? ST_CLEAR : ST_LAUNCH;
            ST_LAUNCH: state_nx = ST_WAIT;
            ST_WAIT:   if (eng_done) state_nx = ST_GUARD;
            ST_CLEAR:  state_nx = ST_GUARD;
            ST_GUARD: begin
                if (launch)              state_nx = op_nop ? ST_CLEAR : ST_LAUNCH;
                else if (gcnt == GLAST)  state_nx = ST_IDLE;
            end
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        eng_start  = (state == ST_LAUNCH);
        in_op      = (state == ST_LAUNCH) || (state == ST_WAIT);
        clr_stat   = (state == ST_CLEAR);
        wr_bit     = in_op || clr_stat;
        guard_busy = (state == ST_GUARD);
        done_evt   = (state == ST_WAIT) && eng_done;
    end
endmodule

// File: rtl/nvc_ctrl.sv
module nvc_ctrl
    import nvc_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32,
    parameter logic [AW-1:0] CTRL_ADDR = 0,
    parameter logic [AW-1:0] KEY_ADDR = 1,
    parameter logic [DW-1:0] KEY_A = 32'h3C5A_A5C3,
    parameter logic [DW-1:0] KEY_B = 32'hC3A5_5A3C,
    parameter int GUARD_CYCLES = 50
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          dev_rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          eng_start,
    output logic [3:0]    eng_op,
    input  logic          eng_done,
    input  logic          eng_fail,
    output logic          lvd_en,
    input  logic          lvd_event,
    output logic          guard_busy
);
    logic sys_rst_n, armed, ctrl_wr, launch;
    logic wr_bit, clr_stat, done_evt, in_op;
    logic wren_q, err_q, lvderr_q, lvdstat_q;
    logic [OPW-1:0] op_q;

    assign sys_rst_n = por_n & dev_rst_n;
    assign ctrl_wr   = bus_wr && (bus_addr == CTRL_ADDR);
    assign launch    = ctrl_wr && bus_wdata[BIT_WR] && wren_q && armed && !wr_bit;

    nvc_unlock #(.AW(AW), .DW(DW), .KEY_ADDR(KEY_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_unlock (
        .clk(clk), .rst_n(sys_rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .armed(armed)
    );

    nvc_fsm #(.GUARD_CYCLES(GUARD_CYCLES)) u_fsm (
        .clk(clk), .rst_n(por_n), .launch(launch), .op_nop(bus_wdata[OPW-1:0] == '0),
        .eng_done(eng_done), .eng_start(eng_start), .wr_bit(wr_bit),
        .guard_busy(guard_busy), .clr_stat(clr_stat), .done_evt(done_evt), .in_op(in_op)
    );

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n)              wren_q <= 1'b0;
        else if (ctrl_wr && !wr_bit) wren_q <= bus_wdata[BIT_WREN];
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            op_q      <= '0;
            err_q     <= 1'b0;
            lvderr_q  <= 1'b0;
            lvdstat_q <= 1'b0;
        end else begin
            if (ctrl_wr && !wr_bit) op_q <= bus_wdata[OPW-1:0];
            if (clr_stat) begin
                err_q     <= 1'b0;
                lvderr_q  <= 1'b0;
                lvdstat_q <= 1'b0;
            end else begin
                if (done_evt && eng_fail)            err_q    <= 1'b1;
                if (in_op && wren_q && lvd_event)    lvderr_q <= 1'b1;
                lvdstat_q <= wren_q && lvd_event;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata[BIT_WR]      = wr_bit;
            bus_rdata[BIT_WREN]    = wren_q;
            bus_rdata[BIT_ERR]     = err_q;
            bus_rdata[BIT_LVDERR]  = lvderr_q;
            bus_rdata[BIT_LVDSTAT] = lvdstat_q;
            bus_rdata[OPW-1:0]     = op_q;
        end
    end

    assign eng_op = op_q;
    assign lvd_en = wren_q;
endmodule

// File: rtl/nvc_ctrl_chk.sv
module nvc_ctrl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       eng_start,
    input logic       eng_done,
    input logic       eng_fail,
    input logic       lvd_event,
    input logic       wr_bit,
    input logic       wren_q,
    input logic       err_q,
    input logic       lvderr_q,
    input logic       guard_busy,
    input logic [3:0] op_q
);
    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!por_n)
        eng_start |=> !eng_start);
    assert_start_busy_R4: assert property (@(posedge clk) disable iff (!por_n)
        eng_start |-> wr_bit);
    assert_start_needs_enable_R2: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wr_bit) |-> $past(wren_q));
    assert_op_frozen_R5: assert property (@(posedge clk) disable iff (!por_n)
        (wr_bit && $past(wr_bit)) |-> $stable(op_q));
    assert_guard_follows_R10: assert property (@(posedge clk) disable iff (!por_n)
        $fell(wr_bit) |-> guard_busy);
    assert_nop_silent_R9: assert property (@(posedge clk) disable iff (!por_n)
        (wr_bit && op_q == 4'd0) |-> !eng_start);
    assert_err_cause_R6: assert property (@(posedge clk) disable iff (!por_n)
        $rose(err_q) |-> $past(eng_done && eng_fail));
    assert_lvderr_cause_R7: assert property (@(posedge clk) disable iff (!por_n)
        $rose(lvderr_q) |-> $past(wren_q && lvd_event));
endmodule

bind nvc_ctrl nvc_ctrl_chk i_chk (
    .clk(clk), .por_n(por_n), .eng_start(eng_start), .eng_done(eng_done),
    .eng_fail(eng_fail), .lvd_event(lvd_event), .wr_bit(wr_bit), .wren_q(wren_q),
    .err_q(err_q), .lvderr_q(lvderr_q), .guard_busy(guard_busy), .op_q(op_q)
);

// File: tb/test_nvc_ctrl.sv
module test_nvc_ctrl;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int G  = 6;
    localparam logic [AW-1:0] CA = 0;
    localparam logic [AW-1:0] KA = 1;
    localparam logic [DW-1:0] K1 = 32'h3C5A_A5C3;
    localparam logic [DW-1:0] K2 = 32'hC3A5_5A3C;

    logic clk = 1'b0, por_n = 1'b0, dev_rst_n = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0, bus_rdata;
    logic eng_start, eng_done, lvd_en, guard_busy;
    logic eng_fail = 1'b0, lvd_event = 1'b0;
    logic [3:0] eng_op;
    logic [3:0] eng_cnt = '0;

    int n_chk = 0, n_err = 0, start_cnt = 0, grun = 0, s0 = 0;
    logic [3:0] exp_op = '0;
    logic [DW-1:0] exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    nvc_ctrl #(.AW(AW), .DW(DW), .CTRL_ADDR(CA), .KEY_ADDR(KA), .KEY_A(K1), .KEY_B(K2),
               .GUARD_CYCLES(G)) i_nvc_ctrl (
        .clk(clk), .por_n(por_n), .dev_rst_n(dev_rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_start(eng_start), .eng_op(eng_op), .eng_done(eng_done), .eng_fail(eng_fail),
        .lvd_en(lvd_en), .lvd_event(lvd_event), .guard_busy(guard_busy)
    );

    // engine model: one done pulse four cycles after each start strobe
    always @(posedge clk) begin
        if (eng_start)         eng_cnt <= 4'd4;
        else if (eng_cnt != 0) eng_cnt <= eng_cnt - 4'd1;
    end
    assign eng_done = (eng_cnt == 4'd1);

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data, watches strobes and guard length
    always @(negedge clk) begin
        if (bus_rd && exp_q.size() != 0) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(bus_rdata == e, t, bus_rdata, e);
        end
        if (eng_start) begin
            start_cnt++;
            check(eng_op == exp_op, "R4 engine code", 32'(eng_op), 32'(exp_op));
        end
        if (guard_busy) grun++;
        else if (grun != 0) begin
            check(grun == G, "R10 guard length", grun, G);
            grun = 0;
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic unlock();
        bus_write(KA, K1);
        bus_write(KA, K2);
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 por_n = 1'b1;
        idle(1);
        rd_exp(CA, 32'h0000_0000, "R11 power-on state");
        check(guard_busy == 1'b0 && eng_start == 1'b0, "R11 outputs idle", 32'(guard_busy), 0);

        // R1 reserved and status bits ignore writes
        bus_write(CA, 32'hFFFF_7FFF);
        rd_exp(CA, 32'h0000_400F, "R1 layout");
        rd_exp(KA, 32'h0000_0000, "R1 key reads zero");

        s0 = start_cnt;
        // R2 no unlock
        bus_write(CA, 32'h0000_C005);
        rd_exp(CA, 32'h0000_4005, "R2 no unlock");
        // R2 enable set in the same write
        bus_write(CA, 32'h0000_0005);
        unlock();
        bus_write(CA, 32'h0000_C005);
        rd_exp(CA, 32'h0000_4005, "R2 enable not prior");
        // R3 broken by read
        bus_write(KA, K1);
        rd_exp(CA, 32'h0000_4005, "R3 mid read");
        bus_write(KA, K2);
        bus_write(CA, 32'h0000_C005);
        rd_exp(CA, 32'h0000_4005, "R3 broken sequence");
        // R3 arm consumed
        unlock();
        bus_write(CA, 32'h0000_4005);
        bus_write(CA, 32'h0000_C005);
        rd_exp(CA, 32'h0000_4005, "R3 arm consumed");
        idle(2);
        check(start_cnt == s0, "R2 R3 no strobe", start_cnt, s0);

        // R4 proper start, R5 writes ignored while running
        exp_op = 4'd5;
        s0 = start_cnt;
        unlock();
        bus_write(CA, 32'h0000_C005);
        rd_exp(CA, 32'h0000_C005, "R4 start bit set");
        bus_write(CA, 32'h0000_0009);
        rd_exp(CA, 32'h0000_C005, "R5 write ignored");
        idle(20);
        rd_exp(CA, 32'h0000_4005, "R4 start bit cleared");
        check(start_cnt == s0 + 1, "R4 one strobe", start_cnt, s0 + 1);

        // R6 failure
        eng_fail = 1'b1;
        unlock();
        bus_write(CA, 32'h0000_C005);
        idle(20);
        eng_fail = 1'b0;
        rd_exp(CA, 32'h0000_6005, "R6 error set");
        unlock();
        bus_write(CA, 32'h0000_C005);
        idle(20);
        rd_exp(CA, 32'h0000_6005, "R6 error sticky");

        // R8 status follows, R7 not latched outside an operation
        lvd_event = 1'b1;
        idle(1);
        rd_exp(CA, 32'h0000_6805, "R8 R7 status only");
        check(lvd_en == 1'b1, "R8 detector enable", 32'(lvd_en), 1);
        lvd_event = 1'b0;
        idle(1);
        rd_exp(CA, 32'h0000_6005, "R8 status follows");

        // R7 latched during an operation
        unlock();
        bus_write(CA, 32'h0000_C005);
        lvd_event = 1'b1;
        idle(2);
        lvd_event = 1'b0;
        idle(20);
        rd_exp(CA, 32'h0000_7005, "R7 error latched");

        // R8 disabled detector
        bus_write(CA, 32'h0000_0005);
        lvd_event = 1'b1;
        idle(1);
        rd_exp(CA, 32'h0000_3005, "R8 disabled status");
        check(lvd_en == 1'b0, "R8 detector off", 32'(lvd_en), 0);
        lvd_event = 1'b0;

        // R9 no-operation clears status
        s0 = start_cnt;
        bus_write(CA, 32'h0000_4000);
        unlock();
        bus_write(CA, 32'h0000_C000);
        rd_exp(CA, 32'h0000_F000, "R9 one busy cycle");
        rd_exp(CA, 32'h0000_4000, "R9 status cleared");
        idle(15);
        check(start_cnt == s0, "R9 no strobe", start_cnt, s0);

        // R11 device reset keeps all but enable
        exp_op = 4'd6;
        bus_write(CA, 32'h0000_4006);
        unlock();
        eng_fail = 1'b1;
        bus_write(CA, 32'h0000_C006);
        idle(20);
        eng_fail = 1'b0;
        rd_exp(CA, 32'h0000_6006, "R6 error again");
        dev_rst_n = 1'b0;
        idle(2);
        dev_rst_n = 1'b1;
        idle(1);
        rd_exp(CA, 32'h0000_2006, "R11 device reset");
        idle(2);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule